// File: doc/BRIEF.md
# Core Soft-Reset and Boot-Vector Controller

This block is a small memory-mapped register slice for a tile with five processor cores. It holds every core in reset from power-up. Software releases the cores one at a time by writing a reset-hold word. The block also supplies the address each core starts fetching from. Core 0 always starts at a fixed default address. Cores 1 to 4 each have a programmable start-address register, which drives that core's start-PC output only while its override enable bit is set; otherwise the output carries the core's default address.

The slice also holds a free-running 64-bit cycle counter. Software reads it as two 32-bit halves over a 32-bit bus. Reading the low half captures the high half into a shadow register, so a later high-half read is consistent with that low half even when a carry crosses between the two reads.

Accesses use a single-cycle request with a write-enable. Read data is registered and appears on the cycle after the request.

Top module: `core_boot_ctrl`

## Requirements
- R1: After reset all five reset outputs are 1 (held), and the reset-hold word at offset 0x1B0 reads 0x00047800.
- R2: Reset output mapping: `core_rst_o[0]` follows bit 11 of the reset-hold word, `[1]` bit 18, `[2]` bit 12, `[3]` bit 13 and `[4]` bit 14. A value of 1 holds the core. A write takes effect on the outputs after the write's clock edge. Writing 0x00047000 releases core 0 only.
- R3: Only bits 11, 12, 13, 14 and 18 of the reset-hold word are stored; every other bit reads 0.
- R4: The start-address registers reset to 0 and read back the last value written. Their offsets are: core 1 at 0x238, core 2 at 0x228, core 3 at 0x22C and core 4 at 0x230.
- R5: Start-PC output k is `core_pc_o[32k+31:32k]`. It equals the default parameter `DEF_PC[k]` while core k's override enable is 0, and the core's start-address register while the enable is 1. Core 0 has no override and always outputs its default.
- R6: Override enables. Bits [2:0] at offset 0x234 enable cores 2, 3 and 4 in that order, and bit 0 at offset 0x23C enables core 1. All enables reset to 0, and their other bits read 0.
- R7: The cycle counter resets to `WALL_INIT` and increments on every clock. A read at 0x1F0 returns the counter's low 32 bits at the read edge.
- R8: A read at 0x1F0 copies the counter's high 32 bits into a shadow register, which resets to 0. Reads at 0x1F8 return the shadow.
- R9: `rdata_o` changes only on a read. It holds the read value from the cycle after the request until the next read.
- R10: Reads of any other offset, including misaligned ones, return 0. Writes to them, and writes to 0x1F0 or 0x1F8, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| core_rst_o | output | N_CORES | Per-core reset hold, 1 = held |
| core_pc_o | output | N_CORES*DATA_W | Per-core start address, core k in slice k |

## Verification
The assertions assume that `addr_i`, `we_i` and `wdata_i` are meaningful only while `req_i` is high. They also assume that at most one access is issued per cycle, and that reset is not reasserted in the middle of a check window. The stimulus respects this by driving every input on the falling edge and presenting one access per request cycle, with `req_i` low in between. Reset is applied only at the start. The counter's initial value is placed 256 cycles below a carry into the high half, so the shadow capture is exercised across a real carry without a long run.

// File: rtl/core_boot_pkg.sv
package core_boot_pkg;
  localparam logic [11:0] OFS_RST     = 12'h1B0;
  localparam logic [11:0] OFS_WALL_LO = 12'h1F0;
  localparam logic [11:0] OFS_WALL_HI = 12'h1F8;
  localparam logic [11:0] OFS_CMP_EN  = 12'h234;
  localparam logic [11:0] OFS_C1_EN   = 12'h23C;
  localparam logic [31:0] RST_POR     = 32'h0004_7800;

  // bit of the reset-hold word that drives core k
  function automatic int unsigned hold_bit(input int unsigned core);
    case (core)
      0:       return 11;
      1:       return 18;
      2:       return 12;
      3:       return 13;
      default: return 14;
    endcase
  endfunction

  function automatic logic [31:0] hold_mask(input int unsigned n);
    logic [31:0] m;
    m = '0;
    for (int unsigned k = 0; k < n; k++) m[hold_bit(k)] = 1'b1;
    return m;
  endfunction

  // start-address register offset of core k (k >= 1)
  function automatic logic [11:0] vec_ofs(input int unsigned core);
    if (core == 1) return 12'h238;
    return 12'h228 + 12'(4 * (core - 2));
  endfunction
endpackage

// File: rtl/boot_rst_ctrl.sv
module boot_rst_ctrl import core_boot_pkg::*; #(
  parameter int unsigned N_CORES = 5,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rst_word_o,
  output logic [N_CORES-1:0] core_rst_o
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(hold_mask(N_CORES));

  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= DATA_W'(RST_POR) & KEEP;
    else if (wr_i) word_q <= wdata_i & KEEP;
  end

  for (genvar k = 0; k < N_CORES; k++) begin : g_hold
    assign core_rst_o[k] = word_q[hold_bit(k)];
  end

  assign rst_word_o = word_q;
endmodule

// File: rtl/boot_vec_bank.sv
module boot_vec_bank #(
  parameter int unsigned N_CORES = 5,
  parameter int unsigned DATA_W  = 32,
  parameter logic [N_CORES-1:0][DATA_W-1:0] DEF_PC = '0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [N_CORES-1:0]             vec_wr_i,
  input  logic                           cmp_en_wr_i,
  input  logic                           c1_en_wr_i,
  output logic [N_CORES-1:0][DATA_W-1:0] vec_q_o,
  output logic [N_CORES-1:0]             en_o,
  output logic [N_CORES-1:0][DATA_W-1:0] pc_o
);
  localparam int unsigned N_CMP = N_CORES - 2;

  logic             c1_en_q;
  logic [N_CMP-1:0] cmp_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_en_q  <= 1'b0;
      cmp_en_q <= '0;
    end else begin
      if (c1_en_wr_i)  c1_en_q  <= wdata_i[0];
      if (cmp_en_wr_i) cmp_en_q <= wdata_i[N_CMP-1:0];
    end
  end

  assign en_o = {cmp_en_q, c1_en_q, 1'b0};

  for (genvar k = 0; k < N_CORES; k++) begin : g_core
    if (k == 0) begin : g_fixed
      logic unused_wr;
      assign unused_wr  = vec_wr_i[0];
      assign vec_q_o[k] = '0;
      assign pc_o[k]    = DEF_PC[k];
    end else begin : g_ovr
      logic [DATA_W-1:0] vec_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          vec_q <= '0;
        else if (vec_wr_i[k]) vec_q <= wdata_i;
      end
      assign vec_q_o[k] = vec_q;
      assign pc_o[k]    = en_o[k] ? vec_q : DEF_PC[k];
    end
  end
endmodule

// File: rtl/wall_clock.sv
module wall_clock #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_lo_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [DATA_W-1:0]       lo_o,
  output logic [CNT_W-DATA_W-1:0] hi_shadow_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_INIT;
      shadow_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (rd_lo_i) shadow_q <= cnt_q[CNT_W-1:DATA_W];
    end
  end

  assign cnt_o       = cnt_q;
  assign lo_o        = cnt_q[DATA_W-1:0];
  assign hi_shadow_o = shadow_q;
endmodule

// File: rtl/core_boot_ctrl.sv
module core_boot_ctrl import core_boot_pkg::*; #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_CORES = 5,
  parameter int unsigned CNT_W   = 64,
  parameter logic [CNT_W-1:0] WALL_INIT = '0,
  parameter logic [N_CORES-1:0][DATA_W-1:0] DEF_PC =
    {32'h0000_4400, 32'h0000_3400, 32'h0000_2400, 32'h0000_1400, 32'h0000_0000}
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [N_CORES-1:0]          core_rst_o,
  output logic [N_CORES*DATA_W-1:0]   core_pc_o
);
  localparam int unsigned HI_W  = CNT_W - DATA_W;
  localparam int unsigned N_CMP = N_CORES - 2;

  logic wr, rd;
  logic hit_rst, hit_lo, hit_hi, hit_cmp_en, hit_c1_en;
  logic [N_CORES-1:0] hit_vec;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign hit_rst    = addr_i == ADDR_W'(OFS_RST);
  assign hit_lo     = addr_i == ADDR_W'(OFS_WALL_LO);
  assign hit_hi     = addr_i == ADDR_W'(OFS_WALL_HI);
  assign hit_cmp_en = addr_i == ADDR_W'(OFS_CMP_EN);
  assign hit_c1_en  = addr_i == ADDR_W'(OFS_C1_EN);

  for (genvar k = 0; k < N_CORES; k++) begin : g_dec
    if (k == 0) begin : g_none
      assign hit_vec[k] = 1'b0;
    end else begin : g_hit
      assign hit_vec[k] = addr_i == ADDR_W'(vec_ofs(k));
    end
  end

  logic [DATA_W-1:0]              rst_word;
  logic [N_CORES-1:0][DATA_W-1:0] vec_q;
  logic [N_CORES-1:0][DATA_W-1:0] pc;
  logic [N_CORES-1:0]             en;
  logic [CNT_W-1:0]               wall_cnt;
  logic [DATA_W-1:0]              wall_lo;
  logic [HI_W-1:0]                wall_shadow;

  boot_rst_ctrl #(.N_CORES(N_CORES), .DATA_W(DATA_W)) u_rst (
    .clk_i, .rst_ni,
    .wr_i       (wr & hit_rst),
    .wdata_i,
    .rst_word_o (rst_word),
    .core_rst_o
  );

  boot_vec_bank #(.N_CORES(N_CORES), .DATA_W(DATA_W), .DEF_PC(DEF_PC)) u_vec (
    .clk_i, .rst_ni,
    .wdata_i,
    .vec_wr_i    ({N_CORES{wr}} & hit_vec),
    .cmp_en_wr_i (wr & hit_cmp_en),
    .c1_en_wr_i  (wr & hit_c1_en),
    .vec_q_o     (vec_q),
    .en_o        (en),
    .pc_o        (pc)
  );

  wall_clock #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CNT_INIT(WALL_INIT)) u_wall (
    .clk_i, .rst_ni,
    .rd_lo_i     (rd & hit_lo),
    .cnt_o       (wall_cnt),
    .lo_o        (wall_lo),
    .hi_shadow_o (wall_shadow)
  );

  for (genvar k = 0; k < N_CORES; k++) begin : g_pc
    assign core_pc_o[k*DATA_W +: DATA_W] = pc[k];
  end

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (hit_rst)    rd_val = rst_word;
    if (hit_lo)     rd_val = wall_lo;
    if (hit_hi)     rd_val = DATA_W'(wall_shadow);
    if (hit_cmp_en) rd_val[N_CMP-1:0] = en[N_CORES-1:2];
    if (hit_c1_en)  rd_val[0] = en[1];
    for (int k = 1; k < N_CORES; k++)
      if (hit_vec[k]) rd_val = vec_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end
endmodule

// File: rtl/core_boot_ctrl_chk.sv
module core_boot_ctrl_chk import core_boot_pkg::*; #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_CORES = 5,
  parameter int unsigned CNT_W   = 64
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        req_i,
  input logic                        we_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [N_CORES-1:0]          hold_bits_i,
  input logic [DATA_W-1:0]           rdata_o,
  input logic [N_CORES-1:0]          core_rst_o,
  input logic [CNT_W-1:0]            cnt_i,
  input logic [CNT_W-DATA_W-1:0]     shadow_i
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic wr_rst, rd_lo, rd_other;
  assign wr_rst = req_i && we_i && addr_i == ADDR_W'(OFS_RST);
  assign rd_lo  = req_i && !we_i && addr_i == ADDR_W'(OFS_WALL_LO);
  assign rd_other = req_i && !we_i
                 && addr_i != ADDR_W'(OFS_RST)    && addr_i != ADDR_W'(OFS_WALL_LO)
                 && addr_i != ADDR_W'(OFS_WALL_HI) && addr_i != ADDR_W'(OFS_CMP_EN)
                 && addr_i != ADDR_W'(OFS_C1_EN)
                 && addr_i != ADDR_W'(vec_ofs(1)) && addr_i != ADDR_W'(vec_ofs(2))
                 && addr_i != ADDR_W'(vec_ofs(3)) && addr_i != ADDR_W'(vec_ofs(4));

  assert_rst_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rst |=> core_rst_o == $past(hold_bits_i));

  assert_rst_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_rst |=> $stable(core_rst_o));

  assert_wall_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> cnt_i == $past(cnt_i) + 1'b1);

  assert_shadow_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> shadow_i == $past(cnt_i[CNT_W-1:DATA_W]));

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_other |=> rdata_o == '0);
endmodule

bind core_boot_ctrl core_boot_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CORES(N_CORES), .CNT_W(CNT_W)
) chk_i (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
  .hold_bits_i ({wdata_i[14], wdata_i[13], wdata_i[12], wdata_i[18], wdata_i[11]}),
  .rdata_o, .core_rst_o,
  .cnt_i    (wall_cnt),
  .shadow_i (wall_shadow)
);

// File: tb/core_boot_ctrl_tb_top.sv
module core_boot_ctrl_tb_top;
  localparam int N  = 5;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam logic [63:0] INIT = 64'h0000_0005_FFFF_FF00;
  localparam logic [N-1:0][DW-1:0] TB_DEF =
    {32'h0000_C400, 32'h0000_B400, 32'h0000_A400, 32'h0000_9400, 32'h0000_8000};
  localparam logic [31:0] KEPT = 32'h0004_7800;  // R3 stored bits

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [N-1:0]  core_rst_o;
  logic [N*DW-1:0] core_pc_o;

  core_boot_ctrl #(.WALL_INIT(INIT), .DEF_PC(TB_DEF)) dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .core_rst_o, .core_pc_o
  );

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [N*DW-1:0] act, input logic [N*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_rst = KEPT;
  logic [31:0] m_vec [N];
  logic        m_c1 = 1'b0;
  logic [2:0]  m_cmp = '0;
  logic [63:0] m_wall = INIT;
  logic [31:0] m_shadow = '0;
  logic [31:0] m_rdata = '0;
  string       m_tag = "R9";

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_rst = KEPT; m_c1 = 1'b0; m_cmp = '0; m_wall = INIT;
      m_shadow = '0; m_rdata = '0; m_tag = "R9";
      for (int k = 0; k < N; k++) m_vec[k] = '0;
    end else begin
      if (req_i && we_i) begin
        case (addr_i)
          12'h1B0: m_rst = wdata_i & KEPT;
          12'h238: m_vec[1] = wdata_i;
          12'h228: m_vec[2] = wdata_i;
          12'h22C: m_vec[3] = wdata_i;
          12'h230: m_vec[4] = wdata_i;
          12'h234: m_cmp = wdata_i[2:0];
          12'h23C: m_c1 = wdata_i[0];
          default: ;
        endcase
      end else if (req_i) begin
        case (addr_i)
          12'h1B0: begin m_rdata = m_rst; m_tag = "R3"; end
          12'h238: begin m_rdata = m_vec[1]; m_tag = "R4"; end
          12'h228: begin m_rdata = m_vec[2]; m_tag = "R4"; end
          12'h22C: begin m_rdata = m_vec[3]; m_tag = "R4"; end
          12'h230: begin m_rdata = m_vec[4]; m_tag = "R4"; end
          12'h234: begin m_rdata = {29'd0, m_cmp}; m_tag = "R6"; end
          12'h23C: begin m_rdata = {31'd0, m_c1}; m_tag = "R6"; end
          12'h1F0: begin m_rdata = m_wall[31:0]; m_shadow = m_wall[63:32]; m_tag = "R7"; end
          12'h1F8: begin m_rdata = m_shadow; m_tag = "R8"; end
          default: begin m_rdata = '0; m_tag = "R10"; end
        endcase
      end
      m_wall = m_wall + 64'd1;
    end
  end

  function automatic logic [N-1:0] exp_rst();
    return {m_rst[14], m_rst[13], m_rst[12], m_rst[18], m_rst[11]};
  endfunction

  function automatic logic [N*DW-1:0] exp_pc();
    logic [N*DW-1:0] v;
    for (int k = 0; k < N; k++) begin
      logic en;
      en = (k == 1) ? m_c1 : (k >= 2) ? m_cmp[k-2] : 1'b0;
      v[k*DW +: DW] = en ? m_vec[k] : TB_DEF[k];
    end
    return v;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R2", "reset pins", {{(N*DW-N){1'b0}}, core_rst_o}, {{(N*DW-N){1'b0}}, exp_rst()});
      chk("R5", "start pcs", core_pc_o, exp_pc());
      chk(m_tag, "rdata", {{(N*DW-DW){1'b0}}, rdata_o}, {{(N*DW-DW){1'b0}}, m_rdata});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i); req_i = 1'b0;
  endtask

  task automatic rd_expect(input logic [11:0] a, input logic [31:0] exp, input string tag);
    rd(a);
    chk(tag, $sformatf("read %03h", a), {{(N*DW-DW){1'b0}}, rdata_o}, {{(N*DW-DW){1'b0}}, exp});
  endtask

  task automatic pin_rst(input logic [N-1:0] exp, input string tag);
    chk(tag, "reset pins", {{(N*DW-N){1'b0}}, core_rst_o}, {{(N*DW-N){1'b0}}, exp});
  endtask

  task automatic pin_pc(input int k, input logic [31:0] exp, input string tag);
    chk(tag, $sformatf("pc core %0d", k), {{(N*DW-DW){1'b0}}, core_pc_o[k*DW +: DW]},
        {{(N*DW-DW){1'b0}}, exp});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 50000);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v1, v2, hold;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    pin_rst(5'h1F, "R1");
    chk("R5", "default pcs", core_pc_o, TB_DEF);

    // wall clock and shadow across a carry into the high half
    rd_expect(12'h1F8, 32'h0, "R8");
    rd(12'h1F0); v1 = rdata_o;
    rd(12'h1F0); v2 = rdata_o;
    chk("R7", "low step", {{(N*DW-DW){1'b0}}, v2 - v1}, 160'd2);
    repeat (300) @(negedge clk_i);
    rd_expect(12'h1F8, 32'h5, "R8");
    rd(12'h1F0);
    rd_expect(12'h1F8, 32'h6, "R8");

    // reset-hold word
    rd_expect(12'h1B0, 32'h0004_7800, "R1");
    wr(12'h1B0, 32'h0004_7000);
    pin_rst(5'b11110, "R2");
    rd_expect(12'h1B0, 32'h0004_7000, "R2");
    wr(12'h1B0, 32'hFFFF_FFFF);
    rd_expect(12'h1B0, 32'h0004_7800, "R3");
    wr(12'h1B0, 32'h0004_0000);
    pin_rst(5'b00010, "R2");
    wr(12'h1B0, 32'h0000_1000);
    pin_rst(5'b00100, "R2");
    wr(12'h1B0, 32'h0);
    pin_rst(5'b00000, "R2");

    // start-address registers and enables
    rd_expect(12'h230, 32'h0, "R4");
    wr(12'h228, 32'hA000_0228);
    rd_expect(12'h228, 32'hA000_0228, "R4");
    pin_pc(2, TB_DEF[2], "R5");
    wr(12'h234, 32'h1);
    pin_pc(2, 32'hA000_0228, "R5");
    wr(12'h22C, 32'hB000_022C);
    wr(12'h230, 32'hC000_0230);
    wr(12'h234, 32'h7);
    rd_expect(12'h234, 32'h7, "R6");
    pin_pc(3, 32'hB000_022C, "R5");
    pin_pc(4, 32'hC000_0230, "R5");
    wr(12'h234, 32'hFFFF_FFFA);
    rd_expect(12'h234, 32'h2, "R6");
    pin_pc(2, TB_DEF[2], "R5");
    pin_pc(3, 32'hB000_022C, "R5");
    wr(12'h238, 32'hD000_0238);
    pin_pc(1, TB_DEF[1], "R5");
    wr(12'h23C, 32'h3);
    rd_expect(12'h23C, 32'h1, "R6");
    pin_pc(1, 32'hD000_0238, "R5");
    rd_expect(12'h238, 32'hD000_0238, "R4");
    pin_pc(0, TB_DEF[0], "R5");

    // unmapped and read-only offsets
    wr(12'h1B4, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h1F0, 32'h1234_5678);
    wr(12'h1F8, 32'h1234_5678);
    wr(12'h1B1, 32'h0);
    rd_expect(12'h1B4, 32'h0, "R10");
    rd_expect(12'h1B1, 32'h0, "R10");
    rd_expect(12'h1B0, 32'h0, "R10");
    rd_expect(12'h1F8, 32'h6, "R10");
    pin_rst(5'b00000, "R10");

    // rdata holds across idle cycles and writes
    rd_expect(12'h238, 32'hD000_0238, "R9");
    hold = rdata_o;
    wr(12'h22C, 32'h1111_2222);
    repeat (3) @(negedge clk_i);
    chk("R9", "rdata hold", {{(N*DW-DW){1'b0}}, rdata_o}, {{(N*DW-DW){1'b0}}, hold});

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule